// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This unit carries out the integer multiply and divide operations of a 64-bit core one at a time, over several cycles. A request is made by raising `start` for one cycle with an operation code and two operands. The unit then becomes busy and runs a fixed number of iterations. It produces the result together with a single-cycle `done` pulse.

Multiplication is shift-and-add over unsigned magnitudes, one multiplier bit per cycle. Division is restoring division, one quotient bit per cycle. Signs are removed from the operands on entry and applied again to the magnitude result at the end. The 32-bit word forms run through the same 64-bit datapath: the low half of each operand is extended on entry, and the low half of the outcome is sign-extended on exit.

Top module: `imuldiv_seq`

## Requirements
- R1: Op code 0, and any code from 13 to 15, returns the low 64 bits of `src_a * src_b`.
- R2: Op codes 1, 2 and 3 return the upper 64 bits of the 128-bit product. Code 1 treats both operands as signed. Code 2 treats `src_a` as signed and `src_b` as unsigned. Code 3 treats both as unsigned.
- R3: Op code 4 multiplies and returns the low 32 bits of the product, sign-extended to 64 bits. Upper operand bits have no effect on the result.
- R4: Op code 5 (signed) and op code 6 (unsigned) return the quotient `src_a / src_b`. The signed quotient is truncated toward zero.
- R5: Op code 7 (signed) and op code 8 (unsigned) return the remainder. A nonzero signed remainder has the sign of the dividend.
- R6: Op codes 9 (signed divide), 10 (unsigned divide), 11 (signed remainder) and 12 (unsigned remainder) use only bits 31:0 of each operand. They return the 32-bit result sign-extended to 64 bits.
- R7: With a zero divisor, every quotient form returns all ones and every remainder form returns the dividend. For the word forms, the divisor is bits 31:0 and the dividend is bits 31:0 sign-extended.
- R8: A signed divide of the most negative value by -1 returns the dividend as the quotient and 0 as the remainder. This holds for the 64-bit forms and for the 32-bit word forms.
- R9: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle. `done` rises on the 65th rising edge after the accepting edge, and `busy` is low in that same cycle.
- R10: A `start` sampled while `busy` is high is ignored. It produces no extra `done` and does not change the pending result or its timing. Operand and op code inputs are ignored after the accepting edge.
- R11: `done` is high for exactly one cycle per accepted request. A `start` presented in the cycle where `done` is high is accepted.
- R12: Driving `rst_n` low immediately sets `busy`, `done` and `result` to 0, whatever the clock is doing, and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| op | input | 4 | Operation code (see R1 to R6) |
| src_a | input | 64 | Multiplicand or dividend |
| src_b | input | 64 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 64 | Result, updated with `done` |

## Verification
The coincidence that matters is a completing result and a new request landing in the same cycle. The bench waits for the cycle where `done` is high and raises `start` in that cycle.

It then checks three things: the finishing result is scored against its own request; the new request is accepted rather than dropped; and the new request completes exactly 66 bench cycles after it was driven. The counterpart case, a `start` raised while the unit is still running, is judged by the absence of any unscheduled `done` and by unchanged latency for the pending item.

// File: rtl/imuldiv_seq.sv
`timescale 1ns/1ps
module imuldiv_seq #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);

  localparam int HW = XLEN / 2;
  localparam int CW = $clog2(XLEN);
  localparam int PW = 2 * XLEN;

  localparam logic [3:0] OP_MUL    = 4'd0;
  localparam logic [3:0] OP_MULHSS = 4'd1;
  localparam logic [3:0] OP_MULHSU = 4'd2;
  localparam logic [3:0] OP_MULHUU = 4'd3;
  localparam logic [3:0] OP_MULW   = 4'd4;
  localparam logic [3:0] OP_DIV    = 4'd5;
  localparam logic [3:0] OP_DIVU   = 4'd6;
  localparam logic [3:0] OP_REM    = 4'd7;
  localparam logic [3:0] OP_REMU   = 4'd8;
  localparam logic [3:0] OP_DIVW   = 4'd9;
  localparam logic [3:0] OP_DIVUW  = 4'd10;
  localparam logic [3:0] OP_REMW   = 4'd11;
  localparam logic [3:0] OP_REMUW  = 4'd12;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] hi_r, lo_r, dv_r;
  logic            div_q, word_q, upper_q, remsel_q, neg_q, bz_q;

  logic is_word, is_div, sgn_a, sgn_b, upper, remsel;
  always_comb begin
    is_word = op inside {OP_MULW, OP_DIVW, OP_DIVUW, OP_REMW, OP_REMUW};
    is_div  = (op >= OP_DIV) && (op <= OP_REMUW);
    sgn_a   = op inside {OP_MULHSS, OP_MULHSU, OP_DIV, OP_REM, OP_DIVW, OP_REMW};
    sgn_b   = op inside {OP_MULHSS, OP_DIV, OP_REM, OP_DIVW, OP_REMW};
    upper   = op inside {OP_MULHSS, OP_MULHSU, OP_MULHUU};
    remsel  = op inside {OP_REM, OP_REMU, OP_REMW, OP_REMUW};
  end

  logic [XLEN-1:0] ext_a, ext_b, mag_a, mag_b;
  logic            neg_a, neg_b, b_zero, res_neg;
  assign ext_a  = is_word ? {{HW{sgn_a & src_a[HW-1]}}, src_a[HW-1:0]} : src_a;
  assign ext_b  = is_word ? {{HW{sgn_b & src_b[HW-1]}}, src_b[HW-1:0]} : src_b;
  assign neg_a  = sgn_a & ext_a[XLEN-1];
  assign neg_b  = sgn_b & ext_b[XLEN-1];
  assign mag_a  = neg_a ? (~ext_a + 1'b1) : ext_a;
  assign mag_b  = neg_b ? (~ext_b + 1'b1) : ext_b;
  assign b_zero = (ext_b == '0);
  assign res_neg = !is_div ? (neg_a ^ neg_b)
                 : remsel  ? neg_a
                 : ((neg_a ^ neg_b) & !b_zero);

  logic [XLEN:0]   mul_sum, div_sh;
  logic [XLEN-1:0] div_df;
  logic            div_ge;
  assign mul_sum = {1'b0, hi_r} + (lo_r[0] ? {1'b0, dv_r} : '0);
  assign div_sh  = {hi_r, lo_r[XLEN-1]};
  assign div_ge  = (div_sh >= {1'b0, dv_r});
  assign div_df  = div_sh[XLEN-1:0] - dv_r;

  logic [PW-1:0]   fin_raw, fin_sgn;
  logic [XLEN-1:0] fin_pick, fin_val;
  assign fin_raw  = div_q ? {{XLEN{1'b0}}, (remsel_q ? hi_r : lo_r)} : {hi_r, lo_r};
  assign fin_sgn  = neg_q ? (~fin_raw + 1'b1) : fin_raw;
  assign fin_pick = upper_q ? fin_sgn[PW-1:XLEN] : fin_sgn[XLEN-1:0];
  assign fin_val  = word_q ? {{HW{fin_pick[HW-1]}}, fin_pick[HW-1:0]} : fin_pick;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      hi_r     <= '0;
      lo_r     <= '0;
      dv_r     <= '0;
      div_q    <= 1'b0;
      word_q   <= 1'b0;
      upper_q  <= 1'b0;
      remsel_q <= 1'b0;
      neg_q    <= 1'b0;
      bz_q     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_RUN;
          cnt      <= '0;
          hi_r     <= '0;
          lo_r     <= mag_a;
          dv_r     <= mag_b;
          div_q    <= is_div;
          word_q   <= is_word;
          upper_q  <= upper;
          remsel_q <= remsel;
          neg_q    <= res_neg;
          bz_q     <= is_div & b_zero;
        end
        S_RUN: begin
          if (div_q) begin
            hi_r <= div_ge ? div_df : div_sh[XLEN-1:0];
            lo_r <= {lo_r[XLEN-2:0], div_ge};
          end else begin
            hi_r <= mul_sum[XLEN:1];
            lo_r <= {mul_sum[0], lo_r[XLEN-1:1]};
          end
          cnt <= cnt + 1'b1;
          if (cnt == CW'(XLEN - 1)) state <= S_FIN;
        end
        S_FIN: begin
          result <= fin_val;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && !done));

  p_word_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && word_q) |-> (result[XLEN-1:HW] == {HW{result[HW-1]}}));

  p_divzero_quot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bz_q && !remsel_q) |-> (&result));

endmodule

// File: tb/imuldiv_seq_tb.sv
`timescale 1ns/1ps
module imuldiv_seq_tb;
  localparam int XLEN = 64;
  localparam int LAT  = 66;
  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  wire         busy, done;
  wire [63:0]  result;

  always #5 clk = ~clk;

  imuldiv_seq #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(a), .src_b(b), .busy(busy), .done(done), .result(result)
  );

  typedef struct {
    logic [63:0] exp;
    int          t0;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic prev_done = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] ref_model(logic [3:0] o, logic [63:0] x, logic [63:0] y);
    logic [127:0] p;
    longint sx, sy;
    int wx, wy;
    logic [31:0] ux, uy;
    sx = x; sy = y; wx = x[31:0]; wy = y[31:0]; ux = x[31:0]; uy = y[31:0];
    case (o)
      4'd1: begin p = {{64{x[63]}}, x} * {{64{y[63]}}, y}; return p[127:64]; end
      4'd2: begin p = {{64{x[63]}}, x} * {64'b0, y}; return p[127:64]; end
      4'd3: begin p = {64'b0, x} * {64'b0, y}; return p[127:64]; end
      4'd4: begin p = {64'b0, x} * {64'b0, y}; return sx32(p[31:0]); end
      4'd5: begin
        if (y == 0) return '1;
        if (x == MIN64 && y == '1) return x;
        return 64'(sx / sy);
      end
      4'd6: return (y == 0) ? '1 : x / y;
      4'd7: begin
        if (y == 0) return x;
        if (x == MIN64 && y == '1) return '0;
        return 64'(sx % sy);
      end
      4'd8: return (y == 0) ? x : x % y;
      4'd9: begin
        if (wy == 0) return '1;
        if (ux == 32'h8000_0000 && wy == -1) return sx32(ux);
        return sx32(32'(wx / wy));
      end
      4'd10: return (uy == 0) ? '1 : sx32(ux / uy);
      4'd11: begin
        if (wy == 0) return sx32(ux);
        if (ux == 32'h8000_0000 && wy == -1) return '0;
        return sx32(32'(wx % wy));
      end
      4'd12: return (uy == 0) ? sx32(ux) : sx32(ux % uy);
      default: begin p = {64'b0, x} * {64'b0, y}; return p[63:0]; end
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] o, logic [63:0] x, logic [63:0] y);
    if (o >= 4'd5 && o <= 4'd8 && y == 0) return "R7";
    if (o >= 4'd9 && o <= 4'd12 && y[31:0] == 0) return "R7";
    if ((o == 4'd5 || o == 4'd7) && x == MIN64 && y == '1) return "R8";
    if ((o == 4'd9 || o == 4'd11) && x[31:0] == 32'h8000_0000 && y[31:0] == '1) return "R8";
    if (o == 4'd0 || o >= 4'd13) return "R1";
    if (o <= 4'd3) return "R2";
    if (o == 4'd4) return "R3";
    if (o <= 4'd6) return "R4";
    if (o <= 4'd8) return "R5";
    return "R6";
  endfunction

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_req(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
    item_t it;
    it.exp = ref_model(o, x, y);
    it.t0  = cyc;
    it.tag = tag_of(o, x, y);
    q.push_back(it);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0; op = 4'hF; a = ~x; b = ~y;
  endtask

  task automatic issue(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    while (busy) @(negedge clk);
    drive_req(o, x, y);
  endtask

  // R11: request presented in the very cycle done is high
  task automatic issue_on_done(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    while (!done) @(negedge clk);
    drive_req(o, x, y);
  endtask

  task automatic wait_empty();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check(1'b0, "R11 done longer than one cycle", 64'd1, 64'd0);
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected done", result, 64'd0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(result === it.exp, it.tag, result, it.exp);
          check((cyc - it.t0) == LAT, "R9 latency", 64'(cyc - it.t0), 64'(LAT));
        end
      end
      prev_done = done;
    end else begin
      prev_done = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_up();
  end

  initial begin
    #23;
    check(busy === 1'b0, "R12 busy in reset", 64'(busy), 64'd0);
    check(done === 1'b0, "R12 done in reset", 64'(done), 64'd0);
    check(result === 64'd0, "R12 result in reset", result, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1
    issue(4'd0, 64'd3, 64'd5);
    issue(4'd0, -64'sd2, 64'd3);
    issue(4'd0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
    issue(4'd13, 64'd7, 64'd9);
    issue(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    // R2
    issue(4'd1, '1, '1);
    issue(4'd1, MIN64, MIN64);
    issue(4'd1, MIN64, 64'd2);
    issue(4'd2, '1, 64'd2);
    issue(4'd2, 64'd5, '1);
    issue(4'd3, '1, '1);
    // R3
    issue(4'd4, 64'hDEAD_BEEF_7FFF_FFFF, 64'hCAFE_0000_0000_0002);
    issue(4'd4, 64'd65536, 64'd65536);
    // R4, R5
    issue(4'd5, -64'sd7, 64'd2);
    issue(4'd5, 64'd7, -64'sd2);
    issue(4'd6, '1, 64'd3);
    issue(4'd7, -64'sd7, 64'd2);
    issue(4'd7, 64'd7, -64'sd2);
    issue(4'd8, '1, 64'd10);
    // R6
    issue(4'd9, 64'hAAAA_AAAA_FFFF_FFF9, 64'h5555_5555_0000_0002);
    issue(4'd10, 64'h1111_1111_FFFF_FFFF, 64'd16);
    issue(4'd11, 64'h0000_0000_FFFF_FFF9, 64'h9999_9999_0000_0002);
    issue(4'd12, 64'h7777_7777_FFFF_FFF1, 64'd7);
    // R7
    issue(4'd5, -64'sd9, 64'd0);
    issue(4'd6, 64'd9, 64'd0);
    issue(4'd7, -64'sd9, 64'd0);
    issue(4'd8, 64'd12345, 64'd0);
    issue(4'd9, 64'd44, 64'hFFFF_FFFF_0000_0000);
    issue(4'd10, 64'd44, 64'h1234_0000_0000_0000);
    issue(4'd11, 64'h0000_0001_8000_0005, 64'hFFFF_0000_0000_0000);
    issue(4'd12, 64'h0000_0000_F000_0000, 64'd0);
    // R8
    issue(4'd5, MIN64, '1);
    issue(4'd7, MIN64, '1);
    issue(4'd9, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
    issue(4'd11, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF);

    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 8; k++) begin
        logic [63:0] x, y;
        x = rnd();
        y = rnd();
        if (k[0]) y = y >> (y[5:0]);
        issue(4'(o), x, y);
      end
    end
    wait_empty();

    // R11: back-to-back requests in the done cycle
    issue(4'd1, 64'd1234567, -64'sd89);
    issue_on_done(4'd7, -64'sd1000, 64'd7);
    issue_on_done(4'd3, 64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF);
    issue_on_done(4'd12, 64'd100, 64'd9);
    wait_empty();

    // R10: start while busy must be ignored
    issue(4'd6, 64'd1000, 64'd3);
    repeat (10) @(negedge clk);
    start = 1'b1; op = 4'd0; a = 64'd5; b = 64'd5;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; op = 4'd8; a = 64'd77; b = 64'd0;
    @(negedge clk);
    start = 1'b0;
    wait_empty();
    repeat (80) @(negedge clk);

    // R12: asynchronous reset in mid operation
    issue(4'd0, 64'd11, 64'd13);
    repeat (20) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(busy === 1'b0, "R12 busy after async reset", 64'(busy), 64'd0);
    check(done === 1'b0, "R12 done after async reset", 64'(done), 64'd0);
    check(result === 64'd0, "R12 result after async reset", result, 64'd0);
    q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (80) @(negedge clk);
    issue(4'd2, -64'sd3, 64'd4);
    wait_empty();
    finish_up();
  end
endmodule